// File: doc/BRIEF.md
# Transmit Bit Collision Detector

This block watches a UART whose receiver hears the transmitter's own output, either through an internal loopback path or through a shared external line. Each time the receiver takes a sample, the block compares the sampled bit with the bit the transmitter was driving. If the two differ, it reports a collision. The serial engines are outside the block. The block has no knowledge of frames. It checks every sample the receiver takes, so start, data, parity and stop bits are all covered in the same way.

The block checks only when two controls are set: the collision-check enable and the receiver enable. It records nothing while the transmit driver is tristated. The driven bit and its output-enable are registered every cycle. A sample strobe therefore compares against the values from the cycle before the strobe, and a change on the transmit line during the strobe cycle cannot affect the result. When loopback is selected, the receive pin is ignored and the receiver sees the driven value.

Every mismatch produces a one-cycle event pulse. It also increments a saturating collision counter and sets a sticky flag. A clear input resets both the counter and the flag. The flag is held by a three-state machine:
- **ST_CLEAN**: no collision since reset or the last clear.
- **ST_FLAGGED**: at least one collision, and the counter is below its maximum.
- **ST_SATURATED**: the counter is at its maximum.

The transitions are:
- **clean_to_flagged**: on a hit.
- **flagged_to_saturated**: on a hit while the counter is one below its maximum.
- **any_to_clean**: on a clear.
- Every other case holds the current state.

Top module: `txcoll_monitor`

## Requirements
- R1: After reset, coll_flag is 0, coll_pulse is 0 and coll_count is 0.
- R2: A hit is a strobe cycle in which both enables are set, the driver was enabled, and the compared receive bit differs from the driven bit. A hit makes coll_pulse 1 for exactly the next cycle, sets coll_flag, and raises coll_count by 1 at that same edge.
- R3: A mismatching sample produces no event while chk_en is 0 or while rx_en is 0.
- R4: A mismatching sample produces no event when tx_oe was 0 in the cycle before the strobe.
- R5: Every strobe is checked independently, including strobes in consecutive cycles. N mismatching strobes give N pulses and a count increase of N.
- R6: The comparison uses tx_line and tx_oe as they were in the cycle before the strobe. Their values in the strobe cycle itself do not matter.
- R7: With loopback at 1, rx_pin is ignored and the compared bit is the driven bit, so no collision is recorded.
- R8: coll_flag stays at 1 until clr, including while checking is disabled.
- R9: coll_count saturates at 255 (all ones for CNT_W = 8). Further hits still pulse but leave the count unchanged.
- R10: clr at an edge makes coll_count 0 and coll_flag 0. If a hit occurs in the same cycle, the clear takes precedence for the count and the flag, but the pulse is still produced.
- R11: Without sample_stb, nothing is recorded, whatever rx_pin holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_line | input | 1 | Bit driven by the transmitter |
| tx_oe | input | 1 | Transmitter output enable (0 = tristated) |
| rx_pin | input | 1 | External receive line |
| loopback | input | 1 | 1 = receiver hears the driven bit internally |
| sample_stb | input | 1 | Receiver sample strobe |
| chk_en | input | 1 | Collision-check enable |
| rx_en | input | 1 | Receiver enable |
| clr | input | 1 | Clears the flag and the counter |
| coll_pulse | output | 1 | One-cycle pulse per collision |
| coll_flag | output | 1 | Sticky collision flag |
| coll_count | output | CNT_W | Saturating collision count |

## Verification
The flag state and the counter are both visible at the ports one edge after a hit. A wrong state transition or a missed increment therefore shows up on coll_flag or coll_count in the cycle after the strobe, and it stays wrong until the next clear. A wrong capture timing for the driven bit only shows up when tx_line changes in the strobe cycle itself, so the bench drives that case directly. Saturation errors become visible after 255 hits, when the count either wraps or stops short.

// File: rtl/txcoll_pkg.sv
package txcoll_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FLAGGED   = 2'd1,
        ST_SATURATED = 2'd2
    } txcoll_state_e;
endpackage

// File: rtl/txcoll_tx_hold.sv
// Holds the driven bit and its enable from the previous cycle.
module txcoll_tx_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_line,
    input  logic tx_oe,
    output logic tx_q,
    output logic oe_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b1;
            oe_q <= 1'b0;
        end else begin
            tx_q <= tx_line;
            oe_q <= tx_oe;
        end
    end
endmodule

// File: rtl/txcoll_compare.sv
// Selects the receive source and decides whether a sample is a collision.
module txcoll_compare (
    input  logic sample_stb,
    input  logic chk_en,
    input  logic rx_en,
    input  logic loopback,
    input  logic rx_pin,
    input  logic tx_q,
    input  logic oe_q,
    output logic hit
);
    logic rx_bit;
    logic armed;

    always_comb begin
        rx_bit = loopback ? tx_q : rx_pin;
        armed  = sample_stb & chk_en & rx_en & oe_q;
        hit    = armed & (rx_bit ^ tx_q);
    end
endmodule

// File: rtl/txcoll_sat_counter.sv
// Saturating event counter with synchronous clear.
module txcoll_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             near_max
);
    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && count != MAX_VAL) begin
            count <= count + ONE;
        end
    end

    assign near_max = (count == MAX_VAL - ONE);
endmodule

// File: rtl/txcoll_monitor.sv
module txcoll_monitor
    import txcoll_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_line,
    input  logic             tx_oe,
    input  logic             rx_pin,
    input  logic             loopback,
    input  logic             sample_stb,
    input  logic             chk_en,
    input  logic             rx_en,
    input  logic             clr,
    output logic             coll_pulse,
    output logic             coll_flag,
    output logic [CNT_W-1:0] coll_count
);
    txcoll_state_e state_q, state_d;
    logic tx_q, oe_q, hit, near_max, pulse_q;

    txcoll_tx_hold i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_line (tx_line),
        .tx_oe   (tx_oe),
        .tx_q    (tx_q),
        .oe_q    (oe_q)
    );

    txcoll_compare i_cmp (
        .sample_stb (sample_stb),
        .chk_en     (chk_en),
        .rx_en      (rx_en),
        .loopback   (loopback),
        .rx_pin     (rx_pin),
        .tx_q       (tx_q),
        .oe_q       (oe_q),
        .hit        (hit)
    );

    txcoll_sat_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .inc      (hit),
        .count    (coll_count),
        .near_max (near_max)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_CLEAN;                       // any_to_clean
        end else if (hit) begin
            unique case (state_q)
                ST_CLEAN:     state_d = ST_FLAGGED;   // clean_to_flagged
                ST_FLAGGED:   state_d = near_max ? ST_SATURATED : ST_FLAGGED;
                ST_SATURATED: state_d = ST_SATURATED;
                default:      state_d = ST_CLEAN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= hit;
        end
    end

    // Outputs
    always_comb begin
        coll_pulse = pulse_q;
        unique case (state_q)
            ST_CLEAN:     coll_flag = 1'b0;
            ST_FLAGGED:   coll_flag = 1'b1;
            ST_SATURATED: coll_flag = 1'b1;
            default:      coll_flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/txcoll_monitor_chk.sv
module txcoll_monitor_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_oe,
    input logic             sample_stb,
    input logic             chk_en,
    input logic             rx_en,
    input logic             clr,
    input logic             coll_pulse,
    input logic             coll_flag,
    input logic [CNT_W-1:0] coll_count
);
    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

    assert_pulse_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        coll_pulse |-> $past(sample_stb));

    assert_pulse_needs_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coll_pulse |-> $past(chk_en && rx_en));

    assert_pulse_needs_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        coll_pulse |-> $past(tx_oe, 2));

    assert_flag_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_pulse && !$past(clr)) |-> coll_flag);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_pulse && !$past(clr) && $past(coll_count) != MAX_VAL)
            |-> coll_count == $past(coll_count) + 1'b1);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_flag && !clr) |=> coll_flag);

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_count == MAX_VAL && !clr) |=> coll_count == MAX_VAL);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (coll_count == '0 && !coll_flag));
endmodule

bind txcoll_monitor txcoll_monitor_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_oe      (tx_oe),
    .sample_stb (sample_stb),
    .chk_en     (chk_en),
    .rx_en      (rx_en),
    .clr        (clr),
    .coll_pulse (coll_pulse),
    .coll_flag  (coll_flag),
    .coll_count (coll_count)
);

// File: tb/test_txcoll_monitor.sv
`timescale 1ns/1ps
module test_txcoll_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_line = 1'b1, tx_oe = 1'b0, rx_pin = 1'b1, loopback = 1'b0;
    logic sample_stb = 1'b0, chk_en = 1'b0, rx_en = 1'b0, clr = 1'b0;
    logic coll_pulse, coll_flag;
    logic [7:0] coll_count;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Reference model state
    int m_cnt = 0;
    bit m_flag = 0, m_pulse = 0, m_txq = 1, m_oeq = 0;

    always #5 clk = ~clk;

    txcoll_monitor i_txcoll_monitor (
        .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .tx_oe(tx_oe),
        .rx_pin(rx_pin), .loopback(loopback), .sample_stb(sample_stb),
        .chk_en(chk_en), .rx_en(rx_en), .clr(clr),
        .coll_pulse(coll_pulse), .coll_flag(coll_flag), .coll_count(coll_count)
    );

    always @(posedge clk) begin
        bit seen, hit;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 0; m_pulse = 0; m_txq = 1; m_oeq = 0;
        end else begin
            seen = loopback ? m_txq : rx_pin;
            hit = sample_stb && chk_en && rx_en && m_oeq && (seen != m_txq);
            m_pulse = hit;
            if (clr) begin
                m_cnt = 0; m_flag = 0;
            end else if (hit) begin
                m_flag = 1;
                if (m_cnt < 255) m_cnt = m_cnt + 1;
            end
            m_txq = tx_line;
            m_oeq = tx_oe;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance one clock, then compare with the model away from the edge.
    task automatic tick();
        @(negedge clk);
        check(coll_pulse == m_pulse, "R2 R5 model pulse", int'(coll_pulse), int'(m_pulse));
        check(coll_flag == m_flag, "R8 model flag", int'(coll_flag), int'(m_flag));
        check(int'(coll_count) == m_cnt, "R9 model count", int'(coll_count), m_cnt);
    endtask

    task automatic strobe(input bit rxv);
        rx_pin = rxv; sample_stb = 1'b1;
        tick();
        sample_stb = 1'b0;
    endtask

    initial begin
        int c0;
        repeat (3) tick();
        check(coll_flag == 0 && coll_pulse == 0 && coll_count == 0, "R1 reset",
              int'(coll_count), 0);
        rst_n = 1'b1;
        tick();
        check(coll_flag == 0 && coll_count == 0, "R1 after release", int'(coll_count), 0);

        // R2: basic mismatch
        chk_en = 1; rx_en = 1; tx_oe = 1; tx_line = 1;
        tick();
        strobe(1'b0);
        check(coll_pulse == 1, "R2 pulse", int'(coll_pulse), 1);
        check(coll_flag == 1, "R2 flag", int'(coll_flag), 1);
        check(coll_count == 1, "R2 count", int'(coll_count), 1);
        tick();
        check(coll_pulse == 0, "R2 pulse width", int'(coll_pulse), 0);

        // matching sample: nothing
        strobe(1'b1);
        check(coll_count == 1 && coll_pulse == 0, "R2 match no event", int'(coll_count), 1);

        // R3: enables
        chk_en = 0; tick();
        strobe(1'b0); tick();
        check(coll_count == 1, "R3 chk_en low", int'(coll_count), 1);
        chk_en = 1; rx_en = 0;
        strobe(1'b0); tick();
        check(coll_count == 1, "R3 rx_en low", int'(coll_count), 1);
        rx_en = 1;

        // R4: tristated driver
        tx_oe = 0; tick();
        strobe(1'b0); tick();
        check(coll_count == 1, "R4 tristate", int'(coll_count), 1);
        // R6: oe raised in the strobe cycle itself is ignored
        tx_oe = 1; strobe(1'b0); tick();
        check(coll_count == 1, "R6 late oe", int'(coll_count), 1);

        // R6: transmit change in the strobe cycle is ignored
        tx_line = 0; tick();
        tx_line = 1; strobe(1'b1);
        check(coll_count == 2, "R6 old bit 0 vs rx 1", int'(coll_count), 2);
        tick();
        tx_line = 0; strobe(1'b1);
        check(coll_count == 2, "R6 old bit 1 vs rx 1", int'(coll_count), 2);

        // R5: back-to-back strobes over a whole frame
        tx_line = 1; tick();
        c0 = int'(coll_count);
        rx_pin = 0; sample_stb = 1;
        for (int i = 0; i < 10; i++) begin
            tick();
            check(coll_pulse == 1 || i == 0, "R5 consecutive pulse", int'(coll_pulse), 1);
        end
        sample_stb = 0; tick();
        check(int'(coll_count) == c0 + 10, "R5 ten hits", int'(coll_count), c0 + 10);

        // R7: loopback ignores rx_pin
        loopback = 1; c0 = int'(coll_count);
        strobe(1'b0); tick();
        check(int'(coll_count) == c0, "R7 loopback", int'(coll_count), c0);
        loopback = 0;

        // R11: no strobe
        rx_pin = 0; repeat (3) tick();
        check(int'(coll_count) == c0 && coll_pulse == 0, "R11 no strobe", int'(coll_count), c0);

        // R8: sticky while disabled
        chk_en = 0; repeat (4) tick();
        check(coll_flag == 1, "R8 sticky", int'(coll_flag), 1);
        chk_en = 1;

        // R10: clear, then clear against a hit
        clr = 1; tick(); clr = 0;
        check(coll_flag == 0 && coll_count == 0, "R10 clear", int'(coll_count), 0);
        clr = 1; strobe(1'b0); clr = 0;
        check(coll_flag == 0 && coll_count == 0, "R10 clear wins", int'(coll_count), 0);
        check(coll_pulse == 1, "R10 pulse kept", int'(coll_pulse), 1);

        // R9: saturation
        rx_pin = 0; sample_stb = 1;
        repeat (300) tick();
        sample_stb = 0; tick();
        check(coll_count == 8'd255, "R9 saturate", int'(coll_count), 255);
        check(coll_flag == 1, "R9 flag", int'(coll_flag), 1);
        strobe(1'b0);
        check(coll_count == 8'd255 && coll_pulse == 1, "R9 pulse at max", int'(coll_count), 255);

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule